// File: doc/BRIEF.md
# Four-Phase Two-Way Crossing Light Controller

This block sequences a junction between an east/west road and a north/south road through four light phases and drives six lamp lines. Two of the phases are greens that hold until a request arrives for that road. The other two are ambers that hold for a fixed number of time units. The time unit is one pulse on a tick strobe, normally one second, that the surrounding logic supplies. The block keeps its own dwell counter, so no outside timer is needed.

The four phases are named EW_GO, EW_AMBER, NS_GO and NS_AMBER. They run in a fixed ring: EW_GO to EW_AMBER on the east/west request (transition T_EW_REQ), EW_AMBER to NS_GO when the dwell expires (T_EW_DWELL), NS_GO to NS_AMBER on the north/south request (T_NS_REQ), and NS_AMBER back to EW_GO when the dwell expires (T_NS_DWELL). The lamp lines and the phase code both come from the registered phase alone.

Top module: `xing_light_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the block enters EW_GO after that edge (phase code 0, lamps 6'b100001) and clears its dwell counter.
- R2: The phase only advances along the ring EW_GO(0) -> EW_AMBER(1) -> NS_GO(2) -> NS_AMBER(3) -> EW_GO(0), at most one step per clock edge. It never skips a phase or goes backwards.
- R3: In EW_GO the block moves to EW_AMBER on the first edge where `req_ew` is high. Without it, the block stays in EW_GO.
- R4: In NS_GO the block moves to NS_AMBER on the first edge where `req_ns` is high. Without it, the block stays in NS_GO.
- R5: EW_AMBER is left for NS_GO on the edge that samples the DWELL_TICKS-th high `tick` (default 4) after entry. A tick sampled on the entry edge itself does not count.
- R6: NS_AMBER is left for EW_GO under the same dwell rule as R5.
- R7: Clock edges where `tick` is low do not shorten an amber dwell. An amber phase with no ticks holds indefinitely.
- R8: A request sampled in a phase that does not wait for it has no effect and is not stored. This covers `req_ew` outside EW_GO and `req_ns` outside NS_GO. After the ring returns to the waiting phase, that phase holds until the request is seen again.
- R9: `lamps[0]` is L1 and `lamps[5]` is L6. The patterns are: EW_GO 6'b100001, EW_AMBER 6'b010001, NS_GO 6'b001100, NS_AMBER 6'b001110. The lamps change only when the phase changes.
- R10: `phase` gives the registered phase code 0..3 in ring order, as listed in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_ew | input | 1 | East/west request (S1), released from EW_GO |
| req_ns | input | 1 | North/south request (S2), released from NS_GO |
| tick | input | 1 | One-cycle time-unit strobe for amber dwells |
| lamps | output | 6 | Lamp lines L1..L6, bit 0 = L1 |
| phase | output | 2 | Current phase code 0..3 |

## Verification
The assertions assume that `rst` is high on the first clock edge and that every input is a clean 0 or 1 at each rising edge. They also assume the requests and the tick are already synchronous, since debouncing happens elsewhere. The bench drives all inputs on the falling edge from $urandom with a fixed seed, so each one is settled one half period before it is sampled. It pulses reset only on whole clock cycles. The random mix makes ticks and requests frequent enough that every transition fires many times. Directed cases add the edge conditions: a tick on the entry edge, long runs with no ticks, and requests held through phases that do not wait for them.

// File: rtl/xing_pkg.sv
package xing_pkg;

    localparam int LAMP_W  = 6;
    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        EW_GO    = 2'd0,
        EW_AMBER = 2'd1,
        NS_GO    = 2'd2,
        NS_AMBER = 2'd3
    } phase_e;

    function automatic logic is_amber(input phase_e p);
        return (p == EW_AMBER) || (p == NS_AMBER);
    endfunction

endpackage

// File: rtl/xing_dwell.sv
module xing_dwell #(
    parameter int DWELL_TICKS = 4,
    localparam int CNT_W = $clog2(DWELL_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] remain
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_TICKS);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - LAST_VAL;
        end
    end

    assign expire = run && tick && (cnt_q == LAST_VAL);
    assign remain = cnt_q;

    AST_DWELL_RESET: assert property (@(posedge clk) rst |=> (remain == '0)); // R1
    AST_DWELL_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (remain == LOAD_VAL)); // R5
    AST_DWELL_NOTICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(remain)); // R7
    AST_DWELL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(remain)); // R8

endmodule

// File: rtl/xing_seq.sv
module xing_seq
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_ew,
    input  logic   req_ns,
    input  logic   expire,
    output logic   load,
    output phase_e state
);

    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EW_GO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            EW_GO: begin
                if (req_ew) begin
                    state_d = EW_AMBER;
                    load    = 1'b1;
                end
            end
            EW_AMBER: begin
                if (expire) begin
                    state_d = NS_GO;
                end
            end
            NS_GO: begin
                if (req_ns) begin
                    state_d = NS_AMBER;
                    load    = 1'b1;
                end
            end
            NS_AMBER: begin
                if (expire) begin
                    state_d = EW_GO;
                end
            end
            default: begin
                state_d = EW_GO;
            end
        endcase
    end

    assign state = state_q;

    AST_SEQ_RESET: assert property (@(posedge clk) rst |=> (state == EW_GO)); // R1
    AST_SEQ_RING: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((state == $past(state)) || (state == phase_e'($past(state) + 2'd1)))); // R2
    AST_EW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == EW_GO && !req_ew) |=> (state == EW_GO)); // R3
    AST_EW_LEAVE: assert property (@(posedge clk) disable iff (rst)
        (state == EW_GO && req_ew) |=> (state == EW_AMBER)); // R3
    AST_NS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == NS_GO && !req_ns) |=> (state == NS_GO)); // R4
    AST_NS_LEAVE: assert property (@(posedge clk) disable iff (rst)
        (state == NS_GO && req_ns) |=> (state == NS_AMBER)); // R4
    AST_AMBER_NOTICK: assert property (@(posedge clk) disable iff (rst)
        (is_amber(state) && !expire) |=> $stable(state)); // R7

endmodule

// File: rtl/xing_lamps.sv
module xing_lamps
    import xing_pkg::*;
(
    input  phase_e            state,
    output logic [LAMP_W-1:0] lamps
);

    always_comb begin
        lamps = '0;
        unique case (state)
            EW_GO:    lamps = 6'b100001;
            EW_AMBER: lamps = 6'b010001;
            NS_GO:    lamps = 6'b001100;
            NS_AMBER: lamps = 6'b001110;
            default:  lamps = 6'b100001;
        endcase
    end

endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
    import xing_pkg::*;
#(
    parameter int DWELL_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_ew,
    input  logic               req_ns,
    input  logic               tick,
    output logic [5:0]         lamps,
    output logic [PHASE_W-1:0] phase
);

    localparam int CNT_W = $clog2(DWELL_TICKS + 1);

    phase_e           state;
    logic             load;
    logic             expire;
    logic [CNT_W-1:0] remain;

    xing_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .req_ew (req_ew),
        .req_ns (req_ns),
        .expire (expire),
        .load   (load),
        .state  (state)
    );

    xing_dwell #(
        .DWELL_TICKS (DWELL_TICKS)
    ) u_dwell (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .run    (is_amber(state)),
        .tick   (tick),
        .expire (expire),
        .remain (remain)
    );

    xing_lamps u_lamps (
        .state (state),
        .lamps (lamps)
    );

    assign phase = PHASE_W'(state);

    AST_LAMPS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        $stable(phase) |-> $stable(lamps)); // R9
    AST_AMBER_ARMED: assert property (@(posedge clk) disable iff (rst)
        (is_amber(state) && remain == '0) |=> (phase == $past(phase))); // R5
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == NS_AMBER && req_ew && !expire) |=> (state == NS_AMBER)); // R8

endmodule

// File: tb/sim_xing_light_ctrl.sv
`timescale 1ns/1ps
module sim_xing_light_ctrl;

    localparam int DW = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_ew = 1'b0;
    logic       req_ns = 1'b0;
    logic       tick = 1'b0;
    logic [5:0] lamps;
    logic [1:0] phase;

    int checks = 0;
    int errors = 0;
    int ex_ph  = 0;
    int ex_cnt = 0;

    always #2 clk = ~clk;

    xing_light_ctrl #(.DWELL_TICKS(DW)) u0 (
        .clk    (clk),
        .rst    (rst),
        .req_ew (req_ew),
        .req_ns (req_ns),
        .tick   (tick),
        .lamps  (lamps),
        .phase  (phase)
    );

    function automatic logic [5:0] exp_lamps(input int p);
        case (p)
            0: return 6'b100001;
            1: return 6'b010001;
            2: return 6'b001100;
            default: return 6'b001110;
        endcase
    endfunction

    function automatic string tag_of(input int p);
        case (p)
            0: return "R3";
            1: return "R5";
            2: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic n,
                        input logic t, input string tag);
        string tg;
        @(negedge clk);
        rst = r; req_ew = e; req_ns = n; tick = t;
        tg = (tag == "") ? tag_of(ex_ph) : tag;
        @(posedge clk);
        if (r) begin
            ex_ph = 0; ex_cnt = 0; tg = (tag == "") ? "R1" : tag;
        end else begin
            case (ex_ph)
                0: if (e) begin ex_ph = 1; ex_cnt = DW; end
                1: if (t) begin
                       if (ex_cnt == 1) ex_ph = 2;
                       if (ex_cnt > 0) ex_cnt--;
                   end
                2: if (n) begin ex_ph = 3; ex_cnt = DW; end
                default: if (t) begin
                       if (ex_cnt == 1) ex_ph = 0;
                       if (ex_cnt > 0) ex_cnt--;
                   end
            endcase
        end
        #1;
        check(tg, int'(phase), ex_ph);             // R2 R10
        check("R9", int'(lamps), int'(exp_lamps(ex_ph)));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1A2B3C4D);
        // R1: reset state
        step(1, 0, 0, 0, "R1");
        step(1, 1, 1, 1, "R1");
        // R3: hold in EW_GO without request; ticks and req_ns ignored (R8)
        for (int i = 0; i < 6; i++) step(0, 0, 1, 1, "R8");
        // R3 and R5: request with tick on the entry edge, tick not counted
        step(0, 1, 0, 1, "R3");
        // R7: no ticks, amber holds
        for (int i = 0; i < 12; i++) step(0, 1, 1, 0, "R7");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R5");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, "R5");
        // R8: req_ew held in NS_GO ignored
        for (int i = 0; i < 5; i++) step(0, 1, 0, 1, "R8");
        step(0, 0, 1, 0, "R4");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, "R6");
        // R8: back in EW_GO, earlier req_ew not latched
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R8");
        // R1: mid-amber reset
        step(0, 1, 0, 0, "R3");
        step(0, 0, 0, 1, "R5");
        step(1, 0, 0, 1, "R1");
        step(0, 0, 0, 1, "R1");
        // random run
        for (int i = 0; i < 4000; i++) begin
            logic r, e, n, t;
            r = ($urandom % 200) == 0;
            e = ($urandom % 6) == 0;
            n = ($urandom % 6) == 0;
            t = ($urandom % 3) == 0;
            step(r, e, n, t, "");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule